// File: doc/BRIEF.md
# Edge-Capturing Interrupt Message Controller

This block gathers eleven level-sensitive interrupt lines, brings them into its clock domain and keeps three views of them: the live level of each line, a sticky record of every line that has risen since software last looked, and a per-line enable. Lines are numbered by input bit: bits 0 to 5 are the six shared expansion-bus interrupt lines, bit 6 the external system-bus interrupt, bit 7 bus error, bit 8 the keyboard/mouse port, bit 9 spare and bit 10 the serial port.

Interrupts leave the block as memory writes. A per-line routing bit picks one of two software-programmed destination registers. When an enabled line rises, the block emits one outbound write whose address is the chosen register with its five low bits forced to zero, and whose data word carries those five bits as the vector. Several lines that rise together are queued and sent one per accepted handshake, lowest line first. Software reads and writes the state through a plain 32-bit register bus with a combinational read path.

Top module: `irq_msg_ctrl`

## Requirements
- R1: After reset every register reads zero and msgValid is low.
- R2: The level register (offset 0x028) shows the current level of each input line; with the default two-stage synchroniser a change driven before a clock edge is visible on a read issued after the third edge.
- R3: A pending bit is set only when its line goes from low to high; a line held high does not set it again once cleared.
- R4: A read of the pending register (offset 0x01C) returns its value and clears it; any write to it clears it whatever the data.
- R5: If a line rises in the same cycle as a pending clear, its bit survives the clear.
- R6: Each rise of a line whose mask bit is 1 yields exactly one message, valid after the fourth clock edge following the change; a line with mask bit 0 yields none.
- R7: A routing bit of 1 sends the line's message to address register 1 (offset 0x010); 0 sends it to address register 0 (offset 0x004).
- R8: The message address is the chosen address register with bits 4:0 cleared; the message data is that register's bits 4:0 zero-extended to 32 bits.
- R9: Request register 0 (offset 0x00C) reads level AND mask AND NOT routing; request register 1 (offset 0x014) reads level AND mask AND routing.
- R10: Writes to the level and both request registers are ignored; the mask (offset 0x018), routing (offset 0x024) and both address registers are read/write; bits above bit 10 of the mask, routing, level, pending and request registers read zero; any other offset reads zero.
- R11: Lines rising together are sent lowest bit first, one per handshake; while msgValid is high and msgReady low the address and data hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| srcIn | input | 11 | Asynchronous interrupt lines, one per bit |
| busAddr | input | 12 | Register byte offset |
| busWrEn | input | 1 | Register write strobe |
| busWrData | input | 32 | Register write data |
| busRdEn | input | 1 | Register read strobe |
| busRdData | output | 32 | Register read data, same cycle as busRdEn |
| msgAddr | output | 32 | Outbound write address |
| msgData | output | 32 | Outbound write data (vector) |
| msgValid | output | 1 | Outbound write offered |
| msgReady | input | 1 | Outbound write accepted |

## Verification
Two functions meet in one cycle here: the clear of the pending register by a bus access and the capture of a fresh rising line into that same register. The bench places a pending read exactly on the edge where a newly driven line is captured, with another line already pending, and judges that the read returns only the old bit while a second read returns only the new one. It also provokes message acceptance in the same cycle as the loading of the next queued message, and judges that order and content survive back-to-back handshakes and stalls.

// File: rtl/irq_msg_pkg.sv
package irq_msg_pkg;

  // Register byte offsets
  localparam int unsigned OFF_ADDR0 = 32'h004;
  localparam int unsigned OFF_REQ0  = 32'h00C;
  localparam int unsigned OFF_ADDR1 = 32'h010;
  localparam int unsigned OFF_REQ1  = 32'h014;
  localparam int unsigned OFF_MASK  = 32'h018;
  localparam int unsigned OFF_PEND  = 32'h01C;
  localparam int unsigned OFF_ROUTE = 32'h024;
  localparam int unsigned OFF_LEVEL = 32'h028;

  typedef enum logic [3:0] {
    RD_NONE,
    RD_ADDR0,
    RD_REQ0,
    RD_ADDR1,
    RD_REQ1,
    RD_MASK,
    RD_PEND,
    RD_ROUTE,
    RD_LEVEL
  } rd_sel_e;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic    wrAddr0;
    logic    wrAddr1;
    logic    wrMask;
    logic    wrRoute;
    logic    clrPend;
    logic    loadMsg;
    rd_sel_e rdSel;
  } strobe_t;

endpackage

// File: rtl/irq_msg_sync.sv
module irq_msg_sync #(
  parameter int WIDTH  = 11,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign dout = din;
    end else begin : g_chain
      logic [STAGES-1:0][WIDTH-1:0] stg;

      always_ff @(posedge clk) begin
        if (rst) begin
          stg <= '0;
        end else begin
          stg[0] <= din;
          for (int i = 1; i < STAGES; i++) begin
            stg[i] <= stg[i-1];
          end
        end
      end

      assign dout = stg[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/irq_msg_seq.sv
module irq_msg_seq
  import irq_msg_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic              queueNz,
  input  logic              msgReady,
  output strobe_t           strb,
  output logic              msgValid
);

  localparam logic [ADDR_W-1:0] A_ADDR0 = ADDR_W'(OFF_ADDR0);
  localparam logic [ADDR_W-1:0] A_REQ0  = ADDR_W'(OFF_REQ0);
  localparam logic [ADDR_W-1:0] A_ADDR1 = ADDR_W'(OFF_ADDR1);
  localparam logic [ADDR_W-1:0] A_REQ1  = ADDR_W'(OFF_REQ1);
  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(OFF_MASK);
  localparam logic [ADDR_W-1:0] A_PEND  = ADDR_W'(OFF_PEND);
  localparam logic [ADDR_W-1:0] A_ROUTE = ADDR_W'(OFF_ROUTE);
  localparam logic [ADDR_W-1:0] A_LEVEL = ADDR_W'(OFF_LEVEL);

  typedef enum logic {ST_IDLE, ST_SEND} state_e;

  state_e  stateQ, stateD;
  rd_sel_e selDec;
  logic    hitAddr0, hitAddr1, hitMask, hitRoute, hitPend;
  logic    loadMsg;

  // Register decode
  always_comb begin
    selDec   = RD_NONE;
    hitAddr0 = 1'b0;
    hitAddr1 = 1'b0;
    hitMask  = 1'b0;
    hitRoute = 1'b0;
    hitPend  = 1'b0;
    case (busAddr)
      A_ADDR0: begin selDec = RD_ADDR0; hitAddr0 = 1'b1; end
      A_REQ0:  selDec = RD_REQ0;
      A_ADDR1: begin selDec = RD_ADDR1; hitAddr1 = 1'b1; end
      A_REQ1:  selDec = RD_REQ1;
      A_MASK:  begin selDec = RD_MASK;  hitMask  = 1'b1; end
      A_PEND:  begin selDec = RD_PEND;  hitPend  = 1'b1; end
      A_ROUTE: begin selDec = RD_ROUTE; hitRoute = 1'b1; end
      A_LEVEL: selDec = RD_LEVEL;
      default: selDec = RD_NONE;
    endcase
  end

  // Outbound sequencing: load a new message whenever the slot is empty
  // or is being emptied by a handshake in this cycle.
  assign loadMsg = queueNz && ((stateQ == ST_IDLE) || msgReady);

  always_comb begin
    stateD = stateQ;
    if (loadMsg) begin
      stateD = ST_SEND;
    end else if ((stateQ == ST_SEND) && msgReady) begin
      stateD = ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ <= ST_IDLE;
    end else begin
      stateQ <= stateD;
    end
  end

  assign msgValid = (stateQ == ST_SEND);

  always_comb begin
    strb         = '0;
    strb.wrAddr0 = busWrEn && hitAddr0;
    strb.wrAddr1 = busWrEn && hitAddr1;
    strb.wrMask  = busWrEn && hitMask;
    strb.wrRoute = busWrEn && hitRoute;
    strb.clrPend = (busWrEn || busRdEn) && hitPend;
    strb.loadMsg = loadMsg;
    strb.rdSel   = busRdEn ? selDec : RD_NONE;
  end

endmodule

// File: rtl/irq_msg_datapath.sv
module irq_msg_datapath
  import irq_msg_pkg::*;
#(
  parameter int NUM_SRC = 11,
  parameter int DATA_W  = 32,
  parameter int VEC_W   = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  strobe_t            strb,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_SRC-1:0] srcSync,
  output logic [DATA_W-1:0]  rdData,
  output logic               queueNz,
  output logic [DATA_W-1:0]  msgAddr,
  output logic [DATA_W-1:0]  msgData,
  output logic [NUM_SRC-1:0] levelQ,
  output logic [NUM_SRC-1:0] pendQ,
  output logic [NUM_SRC-1:0] riseVec,
  output logic [NUM_SRC-1:0] queueQ
);

  logic [DATA_W-1:0]  addr0Q, addr1Q, chosenAddr;
  logic [NUM_SRC-1:0] maskQ, routeQ, pickOh, req0, req1;
  logic [DATA_W-1:0]  msgAddrQ, msgDataQ;

  assign riseVec = srcSync & ~levelQ;
  assign req0    = levelQ & maskQ & ~routeQ;
  assign req1    = levelQ & maskQ & routeQ;
  assign queueNz = |queueQ;

  // Lowest queued line wins
  always_comb begin
    pickOh = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (queueQ[i]) begin
        pickOh    = '0;
        pickOh[i] = 1'b1;
      end
    end
  end

  assign chosenAddr = (|(pickOh & routeQ)) ? addr1Q : addr0Q;

  // Software-visible registers
  always_ff @(posedge clk) begin
    if (rst) begin
      addr0Q <= '0;
      addr1Q <= '0;
      maskQ  <= '0;
      routeQ <= '0;
    end else begin
      if (strb.wrAddr0) addr0Q <= wrData;
      if (strb.wrAddr1) addr1Q <= wrData;
      if (strb.wrMask)  maskQ  <= wrData[NUM_SRC-1:0];
      if (strb.wrRoute) routeQ <= wrData[NUM_SRC-1:0];
    end
  end

  // Level, pending and outbound queue
  always_ff @(posedge clk) begin
    if (rst) begin
      levelQ <= '0;
      pendQ  <= '0;
      queueQ <= '0;
    end else begin
      levelQ <= srcSync;
      pendQ  <= (strb.clrPend ? '0 : pendQ) | riseVec;
      queueQ <= (queueQ & ~(strb.loadMsg ? pickOh : '0)) | (riseVec & maskQ);
    end
  end

  // Message holding register
  always_ff @(posedge clk) begin
    if (rst) begin
      msgAddrQ <= '0;
      msgDataQ <= '0;
    end else if (strb.loadMsg) begin
      msgAddrQ <= {chosenAddr[DATA_W-1:VEC_W], {VEC_W{1'b0}}};
      msgDataQ <= DATA_W'(chosenAddr[VEC_W-1:0]);
    end
  end

  assign msgAddr = msgAddrQ;
  assign msgData = msgDataQ;

  // Read mux
  always_comb begin
    case (strb.rdSel)
      RD_ADDR0: rdData = addr0Q;
      RD_ADDR1: rdData = addr1Q;
      RD_REQ0:  rdData = DATA_W'(req0);
      RD_REQ1:  rdData = DATA_W'(req1);
      RD_MASK:  rdData = DATA_W'(maskQ);
      RD_PEND:  rdData = DATA_W'(pendQ);
      RD_ROUTE: rdData = DATA_W'(routeQ);
      RD_LEVEL: rdData = DATA_W'(levelQ);
      default:  rdData = '0;
    endcase
  end

endmodule

// File: rtl/irq_msg_ctrl.sv
module irq_msg_ctrl
  import irq_msg_pkg::*;
#(
  parameter int NUM_SRC     = 11,
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int VEC_W       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWrEn,
  input  logic [DATA_W-1:0]  busWrData,
  input  logic               busRdEn,
  output logic [DATA_W-1:0]  busRdData,
  output logic [DATA_W-1:0]  msgAddr,
  output logic [DATA_W-1:0]  msgData,
  output logic               msgValid,
  input  logic               msgReady
);

  strobe_t            strb;
  logic [NUM_SRC-1:0] srcSync;
  logic [NUM_SRC-1:0] levelQ, pendQ, riseVec, queueQ;
  logic               queueNz;

  irq_msg_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (srcIn),
    .dout (srcSync)
  );

  irq_msg_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .busAddr  (busAddr),
    .busWrEn  (busWrEn),
    .busRdEn  (busRdEn),
    .queueNz  (queueNz),
    .msgReady (msgReady),
    .strb     (strb),
    .msgValid (msgValid)
  );

  irq_msg_datapath #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .VEC_W(VEC_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .wrData  (busWrData),
    .srcSync (srcSync),
    .rdData  (busRdData),
    .queueNz (queueNz),
    .msgAddr (msgAddr),
    .msgData (msgData),
    .levelQ  (levelQ),
    .pendQ   (pendQ),
    .riseVec (riseVec),
    .queueQ  (queueQ)
  );

endmodule

// File: rtl/irq_msg_chk.sv
module irq_msg_chk #(
  parameter int NUM_SRC = 11,
  parameter int DATA_W  = 32,
  parameter int VEC_W   = 5
) (
  input logic               clk,
  input logic               rst,
  input logic               busWrEn,
  input logic               msgValid,
  input logic               msgReady,
  input logic [DATA_W-1:0]  msgAddr,
  input logic [DATA_W-1:0]  msgData,
  input logic               clrPend,
  input logic [NUM_SRC-1:0] srcSync,
  input logic [NUM_SRC-1:0] levelQ,
  input logic [NUM_SRC-1:0] pendQ,
  input logic [NUM_SRC-1:0] riseVec,
  input logic [NUM_SRC-1:0] queueQ
);

  // R11: a stalled message holds its content
  assert_msg_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (msgValid && !msgReady) |=> (msgValid && $stable(msgAddr) && $stable(msgData)));

  // R8: address aligned, data limited to the vector field
  assert_msg_format_R8: assert property (@(posedge clk) disable iff (rst)
    msgValid |-> ((msgAddr[VEC_W-1:0] == '0) && (msgData[DATA_W-1:VEC_W] == '0)));

  // R5: after a clear only the lines rising in that cycle remain
  assert_pend_clear_R5: assert property (@(posedge clk) disable iff (rst)
    clrPend |=> (pendQ == $past(riseVec)));

  // R3: without a clear, pending gains bits only from rising lines
  assert_pend_edge_R3: assert property (@(posedge clk) disable iff (rst)
    !clrPend |=> ((pendQ & ~$past(pendQ) & ~$past(riseVec)) == '0));

  // R4: without a clear, no pending bit is lost
  assert_pend_keep_R4: assert property (@(posedge clk) disable iff (rst)
    !clrPend |=> (($past(pendQ) & ~pendQ) == '0));

  // R10: a bus write never disturbs the level register
  assert_level_ro_R10: assert property (@(posedge clk) disable iff (rst)
    busWrEn |=> (levelQ == $past(srcSync)));

  // R6: a message appears only when something was queued
  assert_msg_cause_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(msgValid) |-> ($past(queueQ) != '0));

endmodule

bind irq_msg_ctrl irq_msg_chk #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .VEC_W(VEC_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .busWrEn  (busWrEn),
  .msgValid (msgValid),
  .msgReady (msgReady),
  .msgAddr  (msgAddr),
  .msgData  (msgData),
  .clrPend  (strb.clrPend),
  .srcSync  (srcSync),
  .levelQ   (levelQ),
  .pendQ    (pendQ),
  .riseVec  (riseVec),
  .queueQ   (queueQ)
);

// File: tb/irq_msg_ctrl_tb.sv
`timescale 1ns/100ps
module irq_msg_ctrl_tb;

  localparam logic [11:0] O_ADDR0 = 12'h004;
  localparam logic [11:0] O_REQ0  = 12'h00C;
  localparam logic [11:0] O_ADDR1 = 12'h010;
  localparam logic [11:0] O_REQ1  = 12'h014;
  localparam logic [11:0] O_MASK  = 12'h018;
  localparam logic [11:0] O_PEND  = 12'h01C;
  localparam logic [11:0] O_ROUTE = 12'h024;
  localparam logic [11:0] O_LEVEL = 12'h028;
  localparam logic [11:0] O_SPARE = 12'h030;

  localparam logic [31:0] A0 = 32'h8000_1013;
  localparam logic [31:0] A1 = 32'h4000_20A7;

  typedef struct packed {
    logic [10:0] mask;
    logic [10:0] route;
    logic [10:0] pattern;
    logic [3:0]  expCount;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{11'h7FF, 11'h000, 11'h001, 4'd1},
    '{11'h7FF, 11'h008, 11'h00E, 4'd3},
    '{11'h0F0, 11'h000, 11'h0FF, 4'd4},
    '{11'h000, 11'h7FF, 11'h7FF, 4'd0},
    '{11'h401, 11'h001, 11'h401, 4'd2},
    '{11'h7FF, 11'h400, 11'h600, 4'd2}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [10:0] srcIn = '0;
  logic [11:0] busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic        busRdEn = 1'b0;
  logic [31:0] busRdData;
  logic [31:0] msgAddr, msgData;
  logic        msgValid;
  logic        msgReady = 1'b0;

  int nChecks = 0;
  int nFail   = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  irq_msg_ctrl u_dut (
    .clk       (clk),
    .rst       (rst),
    .srcIn     (srcIn),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .busRdEn   (busRdEn),
    .busRdData (busRdData),
    .msgAddr   (msgAddr),
    .msgData   (msgData),
    .msgValid  (msgValid),
    .msgReady  (msgReady)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // All bus tasks start and end just after a falling edge
  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [11:0] a, output logic [31:0] d);
    busAddr = a; busRdEn = 1'b1;
    #1 d = busRdData;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic expectReg(input logic [11:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] v;
    busRead(a, v);
    check(v == exp, tag, v, exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic kthRoute(input logic [10:0] act, input logic [10:0] route, input int k);
    int n = 0;
    for (int i = 0; i < 11; i++) begin
      if (act[i]) begin
        if (n == k) return route[i];
        n++;
      end
    end
    return 1'b0;
  endfunction

  function automatic logic [31:0] expA(input logic useA1);
    return useA1 ? {A1[31:5], 5'b0} : {A0[31:5], 5'b0};
  endfunction

  function automatic logic [31:0] expD(input logic useA1);
    return useA1 ? {27'b0, A1[4:0]} : {27'b0, A0[4:0]};
  endfunction

  // Watchdog
  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int cnt;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    check(msgValid == 1'b0, "R1 msgValid after reset", 32'(msgValid), 32'd0);
    expectReg(O_ADDR0, 32'd0, "R1 addr0 reset");
    expectReg(O_ADDR1, 32'd0, "R1 addr1 reset");
    expectReg(O_MASK,  32'd0, "R1 mask reset");
    expectReg(O_ROUTE, 32'd0, "R1 route reset");
    expectReg(O_PEND,  32'd0, "R1 pending reset");
    expectReg(O_LEVEL, 32'd0, "R1 level reset");
    expectReg(O_REQ0,  32'd0, "R1 req0 reset");
    expectReg(O_REQ1,  32'd0, "R1 req1 reset");

    // R10: read/write and read-only registers, upper bits
    busWrite(O_ADDR0, A0);
    busWrite(O_ADDR1, A1);
    busWrite(O_MASK, 32'hFFFF_FFFF);
    busWrite(O_ROUTE, 32'hFFFF_FFFF);
    expectReg(O_ADDR0, A0, "R10 addr0 readback");
    expectReg(O_ADDR1, A1, "R10 addr1 readback");
    expectReg(O_MASK,  32'h7FF, "R10 mask upper bits zero");
    expectReg(O_ROUTE, 32'h7FF, "R10 route upper bits zero");
    busWrite(O_LEVEL, 32'hFFFF_FFFF);
    busWrite(O_REQ0, 32'hFFFF_FFFF);
    busWrite(O_REQ1, 32'hFFFF_FFFF);
    busWrite(O_SPARE, 32'hFFFF_FFFF);
    expectReg(O_LEVEL, 32'd0, "R10 level ignores write");
    expectReg(O_REQ0,  32'd0, "R10 req0 ignores write");
    expectReg(O_REQ1,  32'd0, "R10 req1 ignores write");
    expectReg(O_SPARE, 32'd0, "R10 spare offset reads zero");
    check(msgValid == 1'b0, "R10 no message from writes", 32'(msgValid), 32'd0);

    // Table of patterns (R6, R7, R8, R9, R11)
    for (int t = 0; t < NVEC; t++) begin
      logic [10:0] act;
      act = VECS[t].pattern & VECS[t].mask;
      busWrite(O_MASK, 32'(VECS[t].mask));
      busWrite(O_ROUTE, 32'(VECS[t].route));
      busRead(O_PEND, v);
      msgReady = 1'b1;
      srcIn = VECS[t].pattern;
      cnt = 0;
      for (int c = 0; c < 16; c++) begin
        @(negedge clk);
        if (msgValid) begin
          check(msgAddr == expA(kthRoute(act, VECS[t].route, cnt)), "R7 R11 message address", msgAddr, expA(kthRoute(act, VECS[t].route, cnt)));
          check(msgData == expD(kthRoute(act, VECS[t].route, cnt)), "R8 message data", msgData, expD(kthRoute(act, VECS[t].route, cnt)));
          cnt++;
        end
      end
      check(cnt == int'(VECS[t].expCount), "R6 message count", 32'(cnt), 32'(VECS[t].expCount));
      msgReady = 1'b0;
      expectReg(O_LEVEL, 32'(VECS[t].pattern), "R2 level pattern");
      expectReg(O_REQ0, 32'(VECS[t].pattern & VECS[t].mask & ~VECS[t].route), "R9 req0");
      expectReg(O_REQ1, 32'(VECS[t].pattern & VECS[t].mask & VECS[t].route), "R9 req1");
      expectReg(O_PEND, 32'(VECS[t].pattern), "R4 pending read");
      expectReg(O_PEND, 32'd0, "R4 pending cleared by read");
      srcIn = '0;
      idle(4);
      expectReg(O_LEVEL, 32'd0, "R2 level falls");
    end

    // R6 / R2 latency, R11 stall hold
    busWrite(O_MASK, 32'h7FF);
    busWrite(O_ROUTE, 32'h000);
    busRead(O_PEND, v);
    srcIn = 11'h004;
    idle(3);
    check(msgValid == 1'b0, "R6 no message before fourth edge", 32'(msgValid), 32'd0);
    expectReg(O_LEVEL, 32'h004, "R2 level after third edge");
    check(msgValid == 1'b1, "R6 message after fourth edge", 32'(msgValid), 32'd1);
    check(msgAddr == expA(1'b0), "R8 address low bits cleared", msgAddr, expA(1'b0));
    idle(3);
    check(msgValid == 1'b1 && msgAddr == expA(1'b0) && msgData == expD(1'b0), "R11 held while stalled", msgData, expD(1'b0));
    msgReady = 1'b1;
    @(negedge clk);
    msgReady = 1'b0;
    check(msgValid == 1'b0, "R6 single message per rise", 32'(msgValid), 32'd0);
    // R3: held line does not set pending again
    busRead(O_PEND, v);
    idle(5);
    expectReg(O_PEND, 32'd0, "R3 held line no re-pend");
    check(msgValid == 1'b0, "R6 held line no second message", 32'(msgValid), 32'd0);
    srcIn = '0;
    idle(4);

    // R4: write clears pending regardless of data
    srcIn = 11'h010;
    idle(5);
    busWrite(O_PEND, 32'h0000_0000);
    expectReg(O_PEND, 32'd0, "R4 write clears pending");
    msgReady = 1'b1;
    idle(3);
    msgReady = 1'b0;
    srcIn = '0;
    idle(4);

    // R5: rise collides with pending clear
    srcIn = 11'h001;
    idle(5);
    srcIn = 11'h003;
    idle(2);
    busRead(O_PEND, v);
    check(v == 32'h001, "R5 read returns old pending", v, 32'h001);
    expectReg(O_PEND, 32'h002, "R5 new rise survives clear");
    msgReady = 1'b1;
    idle(4);
    msgReady = 1'b0;
    srcIn = '0;
    idle(4);

    // R11: simultaneous rises with stall, order and routing
    busWrite(O_ROUTE, 32'h002);
    srcIn = 11'h003;
    idle(4);
    check(msgValid && msgAddr == expA(1'b0), "R11 lowest bit first", msgAddr, expA(1'b0));
    idle(2);
    check(msgValid && msgAddr == expA(1'b0), "R11 first held under stall", msgAddr, expA(1'b0));
    msgReady = 1'b1;
    @(negedge clk);
    msgReady = 1'b0;
    check(msgValid && msgAddr == expA(1'b1) && msgData == expD(1'b1), "R7 R11 second via address 1", msgData, expD(1'b1));
    msgReady = 1'b1;
    @(negedge clk);
    msgReady = 1'b0;
    check(msgValid == 1'b0, "R11 queue drained", 32'(msgValid), 32'd0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule